// File: doc/BRIEF.md
# Byte-Wide Link Transaction Driver

This block sits on the initiating end of a narrow chip-to-chip link that moves one byte per clock. It also carries a parity bit and a copy of the local clock with each byte. A one-cycle command pulse starts a transaction. The pulse carries an operation code, a 32-bit target address and a transfer length. The block then puts that transaction on the link byte by byte. Every transaction starts with a header byte that packs the operation and the length together. The two addressed operations then send the address, most significant byte first.

A write pulls its body bytes one at a time from an on-chip producer through a valid/full handshake. It then holds the link at zero for a two-cycle acknowledge window. A read holds the link at zero for a two-cycle response window and a single dead cycle. It then presents each returned byte to the on-chip consumer with a valid strobe. On each returned byte it checks the incoming parity. While nothing is in flight, the outgoing byte is zero. Any command that arrives while a transaction is running is dropped.

Top module: `byte_link_driver`

## Requirements
- R1: A synchronous active-high reset returns the block to idle within one clock: outgoing byte zero, `src_full` high, `sink_valid` low. Any partly sent transaction is abandoned.
- R2: While idle, `link_tx_data` is 8'h00.
- R3: `link_tx_par` is always the XOR of the eight bits of `link_tx_data` (even parity). `link_tx_clk` is a forwarded copy of `clk`.
- R4: A command is accepted in the cycle that `cmd_op` holds one of the following codes while the block is idle: 3'b001 write, 3'b010 addressed write, 3'b011 read, 3'b100 addressed read. Codes 3'b000 and 3'b101 to 3'b111 leave the block idle.
- R5: In the cycle after an accepted command, the link carries the header `{cmd_op, cmd_len_m1}`. The operation code is in bits 7:5 and the length minus one is in bits 4:0.
- R6: For addressed operations, the four cycles after the header carry `cmd_addr` bits 31:24, 23:16, 15:8 and 7:0, in that order.
- R7: A write moves exactly `cmd_len_m1`+1 body bytes. `src_full` is low only in cycles where the next link byte is to be a body byte: the header of a non-addressed write, the last address cycle of an addressed write, and a body cycle before the last byte. A byte is taken at a clock edge where `src_valid` is high and `src_full` is low, and it appears on the link in the following cycle. If the producer offers nothing in such a cycle, the next link byte is 8'h00 and the block keeps waiting. Bytes offered while `src_full` is high are never sent.
- R8: After the last write body byte, the link carries 8'h00 for two cycles and the block is then idle.
- R9: After the header of a read (or after its last address byte), the link carries 8'h00 for two response cycles, then for one cycle in which `sink_valid` stays low. It then carries 8'h00 for `cmd_len_m1`+1 body cycles. In each body cycle `sink_valid` is high and `sink_data` equals `link_rx_data`. The block is idle afterwards.
- R10: `rx_par_err` is high exactly in read body cycles where `link_rx_par` differs from the XOR of `link_rx_data`.
- R11: A command pulse that arrives while a transaction is in progress has no effect on the link sequence or on the return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_op | input | 3 | Command code, valid for one cycle |
| cmd_addr | input | 32 | Target address, sampled with the command |
| cmd_len_m1 | input | 5 | Transfer length minus one, sampled with the command |
| link_tx_data | output | 8 | Outgoing link byte |
| link_tx_par | output | 1 | Even parity of the outgoing byte |
| link_tx_clk | output | 1 | Forwarded clock |
| link_rx_data | input | 8 | Incoming link byte |
| link_rx_par | input | 1 | Parity of the incoming byte |
| src_valid | input | 1 | Producer has a write byte ready |
| src_data | input | 8 | Producer write byte |
| src_full | output | 1 | High when the block will not take a write byte |
| sink_valid | output | 1 | Returned read byte valid |
| sink_data | output | 8 | Returned read byte |
| rx_par_err | output | 1 | Parity mismatch on a returned byte |

## Verification
The phase sequence is visible only as link bytes and strobes, so an error in the state or the shared counter shows up at the ports. A wrong phase or count gives a wrong link byte, a misplaced `src_full` low window or a misplaced `sink_valid` pulse, and that symptom lands in the very cycle the error happens. Stalled producers, addressed and plain forms, the shortest and the longest length, and commands arriving mid-transaction are all played against a per-cycle expected byte stream. That makes an off-by-one in the acknowledge, response or body count show up as a miscompare on the first wrong cycle.

// File: rtl/byte_link_driver.sv
module byte_link_driver #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 3,
  parameter int SIZE_W = 5,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SIZE_W-1:0] cmd_len_m1,
  output logic [DATA_W-1:0] link_tx_data,
  output logic              link_tx_par,
  output logic              link_tx_clk,
  input  logic [DATA_W-1:0] link_rx_data,
  input  logic              link_rx_par,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_full,
  output logic              sink_valid,
  output logic [DATA_W-1:0] sink_data,
  output logic              rx_par_err
);

  localparam int ADDR_BYTES = ADDR_W / DATA_W;
  localparam int CNT_W      = SIZE_W + 1;
  localparam logic [CODE_W-1:0] OP_WR  = CODE_W'(1);
  localparam logic [CODE_W-1:0] OP_WRA = CODE_W'(2);
  localparam logic [CODE_W-1:0] OP_RDA = CODE_W'(4);

  typedef enum logic [3:0] {
    S_IDLE, S_TXH, S_TXB, S_TXACK, S_ADDR, S_RXH, S_RXRSP, S_RXGAP, S_RXB
  } st_t;

  st_t               state;
  logic [CODE_W-1:0] op;
  logic [SIZE_W-1:0] len_m1;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] tx_q;

  wire               is_addr   = (op == OP_WRA) || (op == OP_RDA);
  wire               is_write  = (op == OP_WR) || (op == OP_WRA);
  wire               last_addr = (cnt == CNT_W'(ADDR_BYTES - 1));
  wire [CNT_W-1:0]   len       = {1'b0, len_m1} + 1'b1;
  wire               cmd_ok    = (cmd_op >= OP_WR) && (cmd_op <= OP_RDA);
  wire               fetch     = (state == S_TXH && !is_addr)
                              || (state == S_ADDR && last_addr && is_write)
                              || (state == S_TXB && cnt != len);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      op     <= '0;
      len_m1 <= '0;
      addr_q <= '0;
      cnt    <= '0;
      tx_q   <= '0;
    end else if (fetch) begin
      if (src_valid) begin
        state <= S_TXB;
        tx_q  <= src_data;
        cnt   <= (state == S_TXB) ? cnt + 1'b1 : CNT_W'(1);
      end else begin
        tx_q <= '0;
      end
    end else begin
      case (state)
        S_IDLE: begin
          tx_q <= '0;
          if (cmd_ok) begin
            op     <= cmd_op;
            len_m1 <= cmd_len_m1;
            addr_q <= cmd_addr;
            cnt    <= '0;
            tx_q   <= {cmd_op, cmd_len_m1};
            state  <= (cmd_op == OP_WR || cmd_op == OP_WRA) ? S_TXH : S_RXH;
          end
        end
        S_TXH, S_RXH: begin
          cnt <= '0;
          if (is_addr) begin
            state  <= S_ADDR;
            tx_q   <= addr_q[ADDR_W-1 -: DATA_W];
            addr_q <= addr_q << DATA_W;
          end else begin
            state <= S_RXRSP;
            tx_q  <= '0;
          end
        end
        S_ADDR: begin
          if (!last_addr) begin
            tx_q   <= addr_q[ADDR_W-1 -: DATA_W];
            addr_q <= addr_q << DATA_W;
            cnt    <= cnt + 1'b1;
          end else begin
            state <= S_RXRSP;
            tx_q  <= '0;
            cnt   <= '0;
          end
        end
        S_TXB: begin
          state <= S_TXACK;
          tx_q  <= '0;
          cnt   <= '0;
        end
        S_TXACK: begin
          if (cnt == CNT_W'(1)) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RXRSP: begin
          if (cnt == CNT_W'(1)) begin
            state <= S_RXGAP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RXGAP: begin
          state <= S_RXB;
          cnt   <= '0;
        end
        S_RXB: begin
          if (cnt == {1'b0, len_m1}) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= S_IDLE;
          tx_q  <= '0;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign link_tx_data = tx_q;
  assign link_tx_par  = ^tx_q;
  assign link_tx_clk  = clk;
  assign src_full     = !fetch;
  assign sink_valid   = (state == S_RXB);
  assign sink_data    = link_rx_data;
  assign rx_par_err   = sink_valid && ((^link_rx_data) != link_rx_par);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (state == S_IDLE && link_tx_data == '0));

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> (link_tx_data == '0));

  p_take_byte_r7: assert property (@(posedge clk) disable iff (rst)
    (src_valid && !src_full) |=> (link_tx_data == $past(src_data)));

  p_body_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_TXB) |-> (cnt <= len && cnt != '0));

  p_ack_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_TXACK && $past(state) != S_TXACK) |=> (state == S_TXACK));

  p_ack_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_TXACK && $past(state) == S_TXACK) |=> (state == S_IDLE));

  p_gap_once_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_RXGAP) |=> (sink_valid && state == S_RXB));

  p_perr_body_r10: assert property (@(posedge clk) disable iff (rst)
    rx_par_err |-> sink_valid);

  p_busy_rx_r11: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> (state != S_RXH));

  p_busy_tx_r11: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && state != S_TXH) |=> (state != S_TXH));

endmodule

// File: tb/tb_byte_link_driver.sv
`timescale 1ns/1ps
module tb_byte_link_driver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_addr = '0;
  logic [4:0]  cmd_len_m1 = '0;
  logic [7:0]  link_tx_data;
  logic        link_tx_par;
  logic        link_tx_clk;
  logic [7:0]  link_rx_data = '0;
  logic        link_rx_par = 1'b0;
  logic        src_valid = 1'b0;
  logic [7:0]  src_data = '0;
  logic        src_full;
  logic        sink_valid;
  logic [7:0]  sink_data;
  logic        rx_par_err;

  int vectors = 0;
  int errors  = 0;

  byte_link_driver dut (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len_m1(cmd_len_m1),
    .link_tx_data(link_tx_data), .link_tx_par(link_tx_par), .link_tx_clk(link_tx_clk),
    .link_rx_data(link_rx_data), .link_rx_par(link_rx_par),
    .src_valid(src_valid), .src_data(src_data), .src_full(src_full),
    .sink_valid(sink_valid), .sink_data(sink_data), .rx_par_err(rx_par_err)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [7:0] etx, bit efull, bit esv, logic [7:0] esd, bit eerr);
    #0.2;
    vectors++;
    if (link_tx_data !== etx || link_tx_par !== ^etx || src_full !== efull ||
        sink_valid !== esv || (esv && sink_data !== esd) || rx_par_err !== eerr ||
        link_tx_clk !== 1'b0) begin
      errors++;
      $display("FAIL %s t=%0t: tx=%h par=%b full=%b sv=%b sd=%h err=%b fclk=%b | expected tx=%h par=%b full=%b sv=%b sd=%h err=%b fclk=0",
               req, $time, link_tx_data, link_tx_par, src_full, sink_valid, sink_data, rx_par_err,
               link_tx_clk, etx, ^etx, efull, esv, esd, eerr);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #0.2;
    vectors++;
    if (link_tx_clk !== 1'b1) begin
      errors++;
      $display("FAIL R3 forwarded clock high phase: got %b expected 1", link_tx_clk);
    end
    @(negedge clk);
  endtask

  task automatic do_write(bit addressed, logic [31:0] a, int len, logic [15:0] stall, logic [7:0] base);
    logic [7:0] hdr;
    logic [7:0] cur;
    int sent = 0;
    int j = 0;
    hdr = {addressed ? 3'b010 : 3'b001, 5'(len - 1)};
    cmd_op = hdr[7:5]; cmd_addr = a; cmd_len_m1 = 5'(len - 1);
    chk("R2 idle before write", 8'h00, 1, 0, 0, 0);
    tick;
    cmd_op = '0; cmd_addr = '0;
    cur = hdr;
    if (addressed) begin
      src_valid = 1'b1; src_data = 8'hEE;
      chk("R5 write header", hdr, 1, 0, 0, 0);
      tick;
      for (int i = 0; i < 3; i++) begin
        chk("R6 write address byte", a[31 - 8*i -: 8], 1, 0, 0, 0);
        tick;
      end
      cur = a[7:0];
    end
    while (sent < len) begin
      bit v;
      v = (j >= 16) ? 1'b1 : !stall[j];
      src_valid = v; src_data = base + 8'(sent);
      chk((j == 0) ? "R5 R6 R7 header or last address with fetch open" : "R7 body fetch", cur, 0, 0, 0, 0);
      tick;
      cur = v ? base + 8'(sent) : 8'h00;
      if (v) sent++;
      j++;
    end
    src_valid = 1'b1; src_data = 8'hEE;
    chk("R7 last body byte", cur, 1, 0, 0, 0);
    tick;
    chk("R8 ack cycle 1", 8'h00, 1, 0, 0, 0);
    tick;
    chk("R8 ack cycle 2", 8'h00, 1, 0, 0, 0);
    tick;
    src_valid = 1'b0;
    chk("R8 idle after ack", 8'h00, 1, 0, 0, 0);
    tick;
  endtask

  task automatic do_read(bit addressed, logic [31:0] a, int len, int bad_idx, bit busy_cmd);
    logic [7:0] hdr;
    hdr = {addressed ? 3'b100 : 3'b011, 5'(len - 1)};
    cmd_op = hdr[7:5]; cmd_addr = a; cmd_len_m1 = 5'(len - 1);
    chk("R2 idle before read", 8'h00, 1, 0, 0, 0);
    tick;
    cmd_op = '0; cmd_addr = '0;
    chk("R5 read header", hdr, 1, 0, 0, 0);
    tick;
    if (addressed) begin
      for (int i = 0; i < 4; i++) begin
        chk("R6 read address byte", a[31 - 8*i -: 8], 1, 0, 0, 0);
        tick;
      end
    end
    if (busy_cmd) begin
      cmd_op = 3'b001; cmd_addr = 32'hFFFF_FFFF; cmd_len_m1 = 5'd7;
    end
    chk("R9 response cycle 1", 8'h00, 1, 0, 0, 0);
    tick;
    cmd_op = '0;
    chk("R9 response cycle 2", 8'h00, 1, 0, 0, 0);
    tick;
    link_rx_data = 8'h5A; link_rx_par = 1'b1;
    chk("R9 R10 dead cycle", 8'h00, 1, 0, 0, 0);
    tick;
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      d = 8'h31 + 8'(i * 7);
      link_rx_data = d;
      link_rx_par = (^d) ^ (i == bad_idx);
      chk((i == bad_idx) ? "R10 bad parity body byte" : "R9 body byte", 8'h00, 1, 1, d, i == bad_idx);
      tick;
    end
    link_rx_data = 8'hFF; link_rx_par = 1'b0;
    if (busy_cmd) cmd_op = '0;
    chk("R9 R10 R11 idle after read", 8'h00, 1, 0, 0, 0);
    tick;
    link_rx_data = '0; link_rx_par = 1'b0;
  endtask

  initial begin
    #250000;
    errors++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset state", 8'h00, 1, 0, 0, 0);
    rst = 1'b0;
    tick;
    chk("R2 idle after reset", 8'h00, 1, 0, 0, 0);
    tick;

    do_write(0, 32'h0, 2, 16'h0000, 8'h01);
    do_write(1, 32'hFA0F_A0FA, 2, 16'h0000, 8'h04);
    do_write(0, 32'h0, 5, 16'b0000_0000_0010_1101, 8'hA0);
    do_write(1, 32'h1234_5678, 1, 16'b0000_0000_0000_0011, 8'hC3);
    do_read(0, 32'h0, 2, -1, 0);
    do_read(1, 32'hFA0F_A0FA, 2, 1, 0);
    do_read(1, 32'h8001_7FFE, 32, 20, 1);
    do_read(0, 32'h0, 1, 0, 1);

    cmd_op = 3'b111;
    chk("R4 reserved code", 8'h00, 1, 0, 0, 0);
    tick;
    cmd_op = 3'b000;
    chk("R4 no state change after reserved code", 8'h00, 1, 0, 0, 0);
    tick;
    cmd_op = 3'b101;
    chk("R4 reserved code 101", 8'h00, 1, 0, 0, 0);
    tick;
    cmd_op = 3'b000;
    chk("R4 still idle", 8'h00, 1, 0, 0, 0);
    tick;

    cmd_op = 3'b001; cmd_len_m1 = 5'd3;
    chk("R1 setup idle", 8'h00, 1, 0, 0, 0);
    tick;
    cmd_op = 3'b000;
    src_valid = 1'b1; src_data = 8'h11;
    chk("R5 header before reset", 8'h23, 0, 0, 0, 0);
    tick;
    rst = 1'b1;
    chk("R7 first byte before reset", 8'h11, 0, 0, 0, 0);
    tick;
    rst = 1'b0; src_valid = 1'b0;
    chk("R1 reset mid write", 8'h00, 1, 0, 0, 0);
    tick;
    chk("R1 stays idle after reset", 8'h00, 1, 0, 0, 0);
    tick;
    do_write(0, 32'h0, 1, 16'h0001, 8'h7E);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule